// File: doc/BRIEF.md
# Prescaled Countdown Interrupt Timer

This block is a per-core countdown timer that raises interrupts. A base tick enable drives it. The tick first passes through a power-of-two prescaler. Software programs three registers: a timer entry, an initial count and a divide setting. The timer entry holds an interrupt vector, a mask flag and a mode flag that selects one-shot or periodic operation.

Writing the initial count starts a run. The current count is always readable. When a run expires, the block emits a one-cycle request together with the vector from the entry. Prioritising that request and delivering it to the core are left to the logic downstream.

Register select codes are: 0 = timer entry, 1 = initial count, 2 = current count (read-only; writes to it are dropped), 3 = divide setting. In the timer entry, bits [7:0] hold the vector, bit 16 is the mask (1 = masked) and bit 17 is the mode (1 = periodic, 0 = one-shot). The divide setting is bits [2:0], written as a shift amount `s`. The count then advances once every 2^s base ticks, and `s` = 0 means every base tick.

Top module: `lct_timer`

## Requirements
- R1: After reset, the timer entry reads with the mask bit (bit 16) set and all other bits zero. The initial count, the current count and the divide setting all read zero, and `irq_o` is low.
- R2: Let n be the number of base ticks seen since the initial-count write, not counting a tick in the write cycle itself. The elapsed prescaled count is then d = n >> s. The current count and any expiry depend only on d.
- R3: In one-shot mode with initial count N > 0, the current count reads N − d while d < N, and reads 0 from then on. Exactly one expiry happens, at d = N + 1, and the timer then stays stopped.
- R4: In periodic mode with initial count N > 0, the current count reads N − (d mod (N + 1)). An expiry happens at every d that is a nonzero multiple of N + 1, and the current count never exceeds the initial count.
- R5: While the mask bit is set, counting continues but `irq_o` stays low. If the mask is set by a write in the cycle an expiry is detected, that pulse is suppressed.
- R6: In periodic mode with an initial count of zero, the current count reads 0 and no expiry ever happens.
- R7: Writing an initial count of zero to a running one-shot timer stops it. The current count reads 0 and no expiry follows.
- R8: An expiry shows as `irq_o` high for exactly one cycle. That cycle follows the clock edge that sampled the deciding base tick, and `irq_vec_o` then carries the entry's vector bits [7:0].
- R9: Changing the mode bit during a run keeps the current count. The new mode governs the next prescaled tick.
- R10: Writing the initial count during a run makes the current count read the new value in the next cycle, and counting restarts from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Base tick enable, one cycle per tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for writes |
| wr_data_i | input | DATA_W | Write data |
| rd_sel_i | input | 2 | Register select for reads |
| rd_data_o | output | DATA_W | Combinational read data |
| irq_o | output | 1 | One-cycle expiry request |
| irq_vec_o | output | 8 | Vector accompanying the request |

## Verification
If the prescaler phase is wrong, every later expiry shifts by whole base ticks. The current-count read shows the shift on the very next prescaled tick, well before the pulse moves. If the count or run state is wrong, the read value departs from the closed-form formula at once, and a pulse is missed or duplicated one period later. The mask and vector paths can only be seen on an expiry cycle, so the bench checks them on every tick cycle, including runs where the mask changes partway through.

// File: rtl/lct_pkg.sv
package lct_pkg;

    localparam int VEC_W        = 8;
    localparam int DIV_W        = 3;
    localparam int PSC_W        = (1 << DIV_W) - 1;
    localparam int ENT_MASK_BIT = 16;
    localparam int ENT_MODE_BIT = 17;

    typedef enum logic [1:0] {
        SEL_ENTRY = 2'd0,
        SEL_INIT  = 2'd1,
        SEL_CUR   = 2'd2,
        SEL_DIV   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             periodic;
        logic             masked;
        logic [VEC_W-1:0] vector;
    } entry_t;

    localparam entry_t ENTRY_RST = '{periodic: 1'b0, masked: 1'b1, vector: '0};

    // Prescaler compare mask: the low 'sh' bits set.
    function automatic logic [PSC_W-1:0] low_ones(input logic [DIV_W-1:0] sh);
        logic [PSC_W-1:0] m;
        for (int i = 0; i < PSC_W; i++) begin
            m[i] = (i < int'(sh));
        end
        return m;
    endfunction

endpackage

// File: rtl/lct_regs.sv
module lct_regs
    import lct_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output entry_t            entry_q,
    output entry_t            entry_next,
    output logic [DATA_W-1:0] init_q,
    output logic [DIV_W-1:0]  div_q,
    output logic              load,
    output logic [DATA_W-1:0] load_val
);

    logic wr_entry, wr_div;

    always_comb begin
        wr_entry = wr_en && (reg_sel_e'(wr_sel) == SEL_ENTRY);
        wr_div   = wr_en && (reg_sel_e'(wr_sel) == SEL_DIV);
        load     = wr_en && (reg_sel_e'(wr_sel) == SEL_INIT);
        load_val = wr_data;
        entry_next = entry_q;
        if (wr_entry) begin
            entry_next.vector   = wr_data[VEC_W-1:0];
            entry_next.masked   = wr_data[ENT_MASK_BIT];
            entry_next.periodic = wr_data[ENT_MODE_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_q <= ENTRY_RST;
            init_q  <= '0;
            div_q   <= '0;
        end else begin
            entry_q <= entry_next;
            if (load)   init_q <= wr_data;
            if (wr_div) div_q  <= wr_data[DIV_W-1:0];
        end
    end

endmodule

// File: rtl/lct_prescaler.sv
module lct_prescaler
    import lct_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic [DIV_W-1:0] shift,
    output logic             ptick
);

    logic [PSC_W-1:0] phase_q;
    logic [PSC_W-1:0] cmp;

    always_comb begin
        cmp   = low_ones(shift);
        ptick = tick && !restart && ((phase_q & cmp) == cmp);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/lct_counter.sv
module lct_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] init_q,
    input  logic              periodic,
    input  logic              ptick,
    output logic [DATA_W-1:0] cur_q,
    output logic              run_q,
    output logic              fire
);

    logic at_zero;

    always_comb begin
        at_zero = (cur_q == '0);
        fire    = ptick && run_q && !load && at_zero;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cur_q <= load_val;
            run_q <= (load_val != '0);
        end else if (ptick && run_q) begin
            if (at_zero) begin
                if (periodic) cur_q <= init_q;
                else          run_q <= 1'b0;
            end else begin
                cur_q <= cur_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/lct_timer.sv
module lct_timer
    import lct_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o,
    output logic [7:0]        irq_vec_o
);

    entry_t            entry_q, entry_next;
    logic [DATA_W-1:0] init_q, load_val, cur_q;
    logic [DIV_W-1:0]  div_q;
    logic              load, ptick, run_q, fire;
    logic              irq_q;
    logic [VEC_W-1:0]  vec_q;

    lct_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en_i),
        .wr_sel     (wr_sel_i),
        .wr_data    (wr_data_i),
        .entry_q    (entry_q),
        .entry_next (entry_next),
        .init_q     (init_q),
        .div_q      (div_q),
        .load       (load),
        .load_val   (load_val)
    );

    lct_prescaler u_psc (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_i),
        .restart (load),
        .shift   (div_q),
        .ptick   (ptick)
    );

    lct_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .init_q   (init_q),
        .periodic (entry_q.periodic),
        .ptick    (ptick),
        .cur_q    (cur_q),
        .run_q    (run_q),
        .fire     (fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            vec_q <= '0;
        end else begin
            irq_q <= fire && !entry_next.masked;
            if (fire) vec_q <= entry_next.vector;
        end
    end

    always_comb begin
        rd_data_o = '0;
        unique case (reg_sel_e'(rd_sel_i))
            SEL_ENTRY: begin
                rd_data_o[VEC_W-1:0]   = entry_q.vector;
                rd_data_o[ENT_MASK_BIT] = entry_q.masked;
                rd_data_o[ENT_MODE_BIT] = entry_q.periodic;
            end
            SEL_INIT: rd_data_o = init_q;
            SEL_CUR:  rd_data_o = cur_q;
            SEL_DIV:  rd_data_o[DIV_W-1:0] = div_q;
            default:  rd_data_o = '0;
        endcase
    end

    assign irq_o     = irq_q;
    assign irq_vec_o = vec_q;

endmodule

// File: rtl/lct_timer_chk.sv
module lct_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_i,
    input logic              irq_o,
    input logic [7:0]        irq_vec_o,
    input logic              ent_masked,
    input logic [7:0]        ent_vector,
    input logic              run_q,
    input logic [DATA_W-1:0] cur_q,
    input logic [DATA_W-1:0] init_q
);

    p_one_cycle_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    p_vector_matches_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (irq_vec_o == ent_vector));

    p_quiet_when_masked_r5: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> !ent_masked);

    p_pulse_needs_tick_r2: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(tick_i));

    p_idle_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> (cur_q == '0));

    p_count_bounded_r4: assert property (@(posedge clk) disable iff (rst)
        cur_q <= init_q);

endmodule

bind lct_timer lct_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .irq_o      (irq_o),
    .irq_vec_o  (irq_vec_o),
    .ent_masked (entry_q.masked),
    .ent_vector (entry_q.vector),
    .run_q      (run_q),
    .cur_q      (cur_q),
    .init_q     (init_q)
);

// File: tb/lct_timer_tb.sv
module lct_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_i = 1'b0;
    logic              wr_en_i = 1'b0;
    logic [1:0]        wr_sel_i = '0;
    logic [DATA_W-1:0] wr_data_i = '0;
    logic [1:0]        rd_sel_i = 2'd2;
    logic [DATA_W-1:0] rd_data_o;
    logic              irq_o;
    logic [7:0]        irq_vec_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Bench model of the programmed state
    int unsigned m_init = 0;
    int unsigned m_shift = 0;
    int unsigned m_n = 0;
    bit          m_per = 1'b0;
    bit          m_mask = 1'b1;
    int unsigned m_vec = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lct_timer #(.DATA_W(DATA_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .rd_sel_i  (rd_sel_i),
        .rd_data_o (rd_data_o),
        .irq_o     (irq_o),
        .irq_vec_o (irq_vec_o)
    );

    function automatic int unsigned exp_count(int unsigned init, bit per, int unsigned d);
        if (per) return (init == 0) ? 0 : init - (d % (init + 1));
        return (d >= init) ? 0 : init - d;
    endfunction

    function automatic bit exp_fire(int unsigned init, bit per, int unsigned d);
        if (init == 0 || d == 0) return 1'b0;
        if (per) return (d % (init + 1)) == 0;
        return d == init + 1;
    endfunction

    function automatic int unsigned entry_word(bit per, bit mask, int unsigned vec);
        return (int'(per) << 17) | (int'(mask) << 16) | (vec & 8'hff);
    endfunction

    task automatic check(bit ok, string tag, int unsigned act, int unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int unsigned sel, int unsigned data);
        wr_en_i = 1'b1; wr_sel_i = sel[1:0]; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
        case (sel)
            0: begin m_per = data[17]; m_mask = data[16]; m_vec = data & 8'hff; end
            1: begin m_init = data; m_n = 0; end
            3: m_shift = data & 7;
            default: ;
        endcase
    endtask

    task automatic read_chk(int unsigned sel, int unsigned exp, string tag);
        rd_sel_i = sel[1:0];
        #1;
        check(rd_data_o == exp, tag, rd_data_o, exp);
        rd_sel_i = 2'd2;
    endtask

    // One cycle, optionally with a base tick, checked against the model
    task automatic step(bit t, string tag);
        bit          f = 1'b0;
        int unsigned d1;
        tick_i = t;
        @(negedge clk);
        tick_i = 1'b0;
        if (t) begin
            int unsigned d0 = m_n >> m_shift;
            m_n++;
            d1 = m_n >> m_shift;
            f = (d1 != d0) && exp_fire(m_init, m_per, d1);
        end
        d1 = m_n >> m_shift;
        check(irq_o == (f && !m_mask), tag, irq_o, f && !m_mask);
        if (irq_o && f) check(irq_vec_o == m_vec, "R8 vector", irq_vec_o, m_vec);
        check(rd_data_o == exp_count(m_init, m_per, d1), tag, rd_data_o,
              exp_count(m_init, m_per, d1));
    endtask

    // Directed step with explicit expectations
    task automatic dstep(bit t, bit exp_irq, int unsigned exp_cnt, string tag);
        tick_i = t;
        @(negedge clk);
        tick_i = 1'b0;
        check(irq_o == exp_irq, tag, irq_o, exp_irq);
        check(rd_data_o == exp_cnt, tag, rd_data_o, exp_cnt);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c3a_5e71));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        read_chk(0, 32'h0001_0000, "R1 entry");
        read_chk(1, 0, "R1 init");
        read_chk(2, 0, "R1 cur");
        read_chk(3, 0, "R1 div");
        check(irq_o == 1'b0, "R1 irq", irq_o, 0);

        // R3 one-shot, divide by 1
        wr(0, entry_word(0, 0, 8'h41));
        wr(1, 3);
        read_chk(2, 3, "R10 load value");
        for (int i = 0; i < 8; i++) step(1'b1, "R3 one-shot");

        // R2 prescale divide by 4, one-shot
        wr(3, 2);
        wr(1, 2);
        for (int i = 0; i < 16; i++) step(($urandom % 3) != 0, "R2 prescale");

        // R4 periodic, divide by 2
        wr(3, 1);
        wr(0, entry_word(1, 0, 8'h9c));
        wr(1, 2);
        for (int i = 0; i < 30; i++) step(1'b1, "R4 periodic");

        // R5 mask during a periodic run, counting continues
        wr(3, 0);
        wr(0, entry_word(1, 1, 8'h9c));
        wr(1, 1);
        for (int i = 0; i < 8; i++) step(1'b1, "R5 masked");
        wr(0, entry_word(1, 0, 8'h9c));
        for (int i = 0; i < 6; i++) step(1'b1, "R5 unmasked");

        // R6 periodic with zero initial count
        wr(1, 0);
        for (int i = 0; i < 10; i++) step(1'b1, "R6 zero periodic");

        // R7 one-shot stopped by writing zero
        wr(0, entry_word(0, 0, 8'h22));
        wr(1, 5);
        step(1'b1, "R7 pre");
        step(1'b1, "R7 pre");
        wr(1, 0);
        read_chk(2, 0, "R7 stopped count");
        for (int i = 0; i < 10; i++) dstep(1'b1, 1'b0, 0, "R7 no expiry");

        // R10 reload mid-run
        wr(1, 6);
        step(1'b1, "R10 pre");
        step(1'b1, "R10 pre");
        wr(1, 9);
        read_chk(2, 9, "R10 reload");
        step(1'b1, "R10 restart");

        // R9 mode change mid-run keeps the count
        wr(0, entry_word(1, 0, 8'h77));
        wr(1, 3);
        dstep(1, 0, 2, "R9 pre"); dstep(1, 0, 1, "R9 pre"); dstep(1, 0, 0, "R9 pre");
        dstep(1, 1, 3, "R9 wrap"); dstep(1, 0, 2, "R9 pre");
        wr(0, entry_word(0, 0, 8'h77));
        read_chk(2, 2, "R9 count kept");
        dstep(1, 0, 1, "R9 one-shot"); dstep(1, 0, 0, "R9 one-shot");
        dstep(1, 1, 0, "R9 final expiry");
        check(irq_vec_o == 8'h77, "R8 vector", irq_vec_o, 8'h77);
        for (int i = 0; i < 5; i++) dstep(1'b1, 1'b0, 0, "R9 stopped");

        // Random runs
        for (int r = 0; r < 40; r++) begin
            wr(3, $urandom % 3);
            wr(0, entry_word($urandom % 2, ($urandom % 4) == 0, $urandom % 256));
            wr(1, $urandom % 7);
            for (int c = 0; c < 40 + int'($urandom % 40); c++) begin
                if (($urandom % 16) == 0) wr(0, entry_word(m_per, !m_mask, m_vec));
                else step(($urandom % 4) != 0, "R2 R3 R4 R5 random");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule